// File: doc/BRIEF.md
# PLL Digital Lock Detector and Status Output Selector

This block watches a phase-locked loop from the digital side. Both the reference divider and the feedback divider deliver a one-cycle pulse on their active edge. The pulses are synchronous to a fast sampling clock. For each pair of edges, the block counts the sampling cycles between them, and that count is the phase error. A run of small errors declares lock. A single error above a wider threshold drops lock. The band between the two thresholds gives hysteresis.

The lock result also gates the RF output enable when mute-until-locked is selected. A 3-bit selector chooses what appears on one shared status pin:

- the lock flag,
- either divider output,
- serial data,
- the open-drain analog lock signal,
- a fixed level,
- nothing (pin released).

Top module: `pll_lock_monitor`

## Requirements
- R1: Phase error is the number of sampling-clock cycles from the first divider edge to the second, whichever edge leads. Edges in the same cycle give an error of 0.
- R2: With `precisionSel` = 0, `lockDet` rises one cycle after the closing edge of the 3rd consecutive measurement whose error is below `ENTRY_CYC` (default 15).
- R3: With `precisionSel` = 1, 5 consecutive measurements below `ENTRY_CYC` are needed before `lockDet` rises.
- R4: While unlocked, a measurement with error at or above `ENTRY_CYC` restarts the consecutive count from zero.
- R5: While locked, one measurement with error above `EXIT_CYC` (default 25) clears `lockDet`. Errors up to and including `EXIT_CYC` keep it set.
- R6: `powerDown` high clears `lockDet` and the consecutive count on the next clock, and abandons any measurement in progress.
- R7: `rfOutEn` is 1 only when `powerDown` is 0 and either `muteTillLock` is 0 or `lockDet` is 1.
- R8: `muxSel` routes to `statusOut` with `statusOe` = 1 as follows:
  - 001: `lockDet`
  - 010: `fbDivOut`
  - 011: constant 1
  - 100: `refDivOut`
  - 110: `serialData`
  - 111: constant 0
- R9: `muxSel` = 000 sets `statusOe` = 0. `muxSel` = 101 acts as an open drain: `statusOut` = 0 and `statusOe` = NOT `analogLock`.
- R10: After reset, `lockDet` is 0. With `muteTillLock` = 1, `rfOutEn` is then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| powerDown | input | 1 | Power-down; clears the detector |
| refEdge | input | 1 | One-cycle pulse on reference divider edge |
| fbEdge | input | 1 | One-cycle pulse on feedback divider edge |
| refDivOut | input | 1 | Reference divider output level |
| fbDivOut | input | 1 | Feedback divider output level |
| precisionSel | input | 1 | 0: 3-cycle entry, 1: 5-cycle entry |
| muteTillLock | input | 1 | Hold RF output off until lock |
| muxSel | input | 3 | Status pin source select |
| serialData | input | 1 | Serial data to be observed |
| analogLock | input | 1 | Analog lock level, high when locked |
| lockDet | output | 1 | Digital lock flag, active high |
| rfOutEn | output | 1 | RF output stage enable |
| statusOut | output | 1 | Status pin value |
| statusOe | output | 1 | Status pin drive enable |

## Verification
The assertions check three things on every cycle:
- a locked detector drops on any error above the exit threshold and holds on errors up to it;
- lock never rises except on a small-error measurement;
- power-down clears the flag, and the three-state and mute rules hold.

Only the bench scenarios can show the exact run lengths of 3 and 5, the restart of the run after an error at the entry threshold, the threshold edges at 14/15 and 25/26, and the mapping of every selector code.

// File: rtl/lock_det_pkg.sv
package lock_det_pkg;

  // Strobes from the edge sequencer to the error/lock datapath
  typedef struct packed {
    logic errClr;    // abandon the current count
    logic errInc;    // one more cycle between edges
    logic measDone;  // closing edge seen, count is valid this cycle
  } meas_strobe_t;

  typedef enum logic [1:0] {
    SEQ_IDLE     = 2'd0,
    SEQ_WAIT_FB  = 2'd1,
    SEQ_WAIT_REF = 2'd2
  } seq_state_t;

  typedef enum logic [2:0] {
    SEL_HIZ     = 3'b000,
    SEL_DLOCK   = 3'b001,
    SEL_FBDIV   = 3'b010,
    SEL_HIGH    = 3'b011,
    SEL_REFDIV  = 3'b100,
    SEL_ALOCK   = 3'b101,
    SEL_SDATA   = 3'b110,
    SEL_LOW     = 3'b111
  } status_sel_t;

endpackage

// File: rtl/lock_edge_ctrl.sv
module lock_edge_ctrl
  import lock_det_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         powerDown,
  input  logic         refEdge,
  input  logic         fbEdge,
  output meas_strobe_t strb
);

  seq_state_t state, stateNxt;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    if (powerDown) begin
      strb.errClr = 1'b1;
      stateNxt    = SEQ_IDLE;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (refEdge && fbEdge) begin
            strb.measDone = 1'b1;
          end else if (refEdge) begin
            strb.errInc = 1'b1;
            stateNxt    = SEQ_WAIT_FB;
          end else if (fbEdge) begin
            strb.errInc = 1'b1;
            stateNxt    = SEQ_WAIT_REF;
          end
        end
        SEQ_WAIT_FB: begin
          if (fbEdge) begin
            strb.measDone = 1'b1;
            stateNxt      = SEQ_IDLE;
          end else begin
            strb.errInc = 1'b1;
          end
        end
        SEQ_WAIT_REF: begin
          if (refEdge) begin
            strb.measDone = 1'b1;
            stateNxt      = SEQ_IDLE;
          end else begin
            strb.errInc = 1'b1;
          end
        end
        default: stateNxt = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNxt;
  end

  // R1: a measurement closes only when the lagging edge arrives
  a_r1_close_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    strb.measDone |-> (refEdge || fbEdge));

  // R6: power-down abandons any measurement
  a_r6_pd_idle: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> (state == SEQ_IDLE));

endmodule

// File: rtl/lock_err_path.sv
module lock_err_path
  import lock_det_pkg::*;
#(
  parameter int ENTRY_CYC = 15,
  parameter int EXIT_CYC  = 25,
  parameter int SHORT_RUN = 3,
  parameter int LONG_RUN  = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         precisionSel,
  input  meas_strobe_t strb,
  output logic         locked
);

  localparam int ERR_W = $clog2(EXIT_CYC + 2) + 1;
  localparam int RUN_W = $clog2(LONG_RUN + 1);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [ERR_W-1:0] errCnt;
  logic [RUN_W-1:0] runCnt;
  logic [RUN_W-1:0] runTarget;
  logic [RUN_W-1:0] runNext;
  logic             isSmall;
  logic             isLarge;

  assign runTarget = precisionSel ? RUN_W'(LONG_RUN) : RUN_W'(SHORT_RUN);
  assign runNext   = runCnt + 1'b1;
  assign isSmall   = (32'(errCnt) < ENTRY_CYC);
  assign isLarge   = (32'(errCnt) > EXIT_CYC);

  // Saturating cycle counter between the two edges
  always_ff @(posedge clk) begin
    if (!rstN || strb.errClr || strb.measDone) errCnt <= '0;
    else if (strb.errInc && errCnt != ERR_MAX)  errCnt <= errCnt + 1'b1;
  end

  // Entry run counter and lock flag with hysteresis
  always_ff @(posedge clk) begin
    if (!rstN || strb.errClr) begin
      runCnt <= '0;
      locked <= 1'b0;
    end else if (strb.measDone) begin
      if (!locked) begin
        if (isSmall) begin
          if (runNext >= runTarget) begin
            locked <= 1'b1;
            runCnt <= '0;
          end else begin
            runCnt <= runNext;
          end
        end else begin
          runCnt <= '0;
        end
      end else if (isLarge) begin
        locked <= 1'b0;
        runCnt <= '0;
      end
    end
  end

  a_r5_drop_large: assert property (@(posedge clk) disable iff (!rstN)
    (locked && strb.measDone && 32'(errCnt) > EXIT_CYC) |=> !locked);

  a_r5_hold_mid: assert property (@(posedge clk) disable iff (!rstN)
    (locked && strb.measDone && !strb.errClr && 32'(errCnt) <= EXIT_CYC) |=> locked);

  a_r2_rise_small: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(strb.measDone && 32'(errCnt) < ENTRY_CYC));

  a_r6_pd_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.errClr |=> (!locked && runCnt == '0));

endmodule

// File: rtl/status_out_sel.sv
module status_out_sel
  import lock_det_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] muxSel,
  input  logic       lockDet,
  input  logic       refDivOut,
  input  logic       fbDivOut,
  input  logic       serialData,
  input  logic       analogLock,
  output logic       statusOut,
  output logic       statusOe
);

  always_comb begin
    statusOut = 1'b0;
    statusOe  = 1'b1;
    unique case (status_sel_t'(muxSel))
      SEL_HIZ:    statusOe  = 1'b0;
      SEL_DLOCK:  statusOut = lockDet;
      SEL_FBDIV:  statusOut = fbDivOut;
      SEL_HIGH:   statusOut = 1'b1;
      SEL_REFDIV: statusOut = refDivOut;
      SEL_ALOCK:  statusOe  = !analogLock;
      SEL_SDATA:  statusOut = serialData;
      SEL_LOW:    statusOut = 1'b0;
      default:    statusOe  = 1'b0;
    endcase
  end

  a_r9_hiz: assert property (@(posedge clk) disable iff (!rstN)
    (muxSel == 3'b000) |-> !statusOe);

  a_r9_open_drain: assert property (@(posedge clk) disable iff (!rstN)
    (muxSel == 3'b101 && statusOe) |-> !statusOut);

endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
  import lock_det_pkg::*;
#(
  parameter int ENTRY_CYC = 15,
  parameter int EXIT_CYC  = 25,
  parameter int SHORT_RUN = 3,
  parameter int LONG_RUN  = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerDown,
  input  logic       refEdge,
  input  logic       fbEdge,
  input  logic       refDivOut,
  input  logic       fbDivOut,
  input  logic       precisionSel,
  input  logic       muteTillLock,
  input  logic [2:0] muxSel,
  input  logic       serialData,
  input  logic       analogLock,
  output logic       lockDet,
  output logic       rfOutEn,
  output logic       statusOut,
  output logic       statusOe
);

  meas_strobe_t strb;

  lock_edge_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .powerDown (powerDown),
    .refEdge   (refEdge),
    .fbEdge    (fbEdge),
    .strb      (strb)
  );

  lock_err_path #(
    .ENTRY_CYC (ENTRY_CYC),
    .EXIT_CYC  (EXIT_CYC),
    .SHORT_RUN (SHORT_RUN),
    .LONG_RUN  (LONG_RUN)
  ) path_i (
    .clk          (clk),
    .rstN         (rstN),
    .precisionSel (precisionSel),
    .strb         (strb),
    .locked       (lockDet)
  );

  status_out_sel mux_i (
    .clk        (clk),
    .rstN       (rstN),
    .muxSel     (muxSel),
    .lockDet    (lockDet),
    .refDivOut  (refDivOut),
    .fbDivOut   (fbDivOut),
    .serialData (serialData),
    .analogLock (analogLock),
    .statusOut  (statusOut),
    .statusOe   (statusOe)
  );

  assign rfOutEn = !powerDown && (!muteTillLock || lockDet);

  a_r7_mute_gate: assert property (@(posedge clk) disable iff (!rstN)
    (muteTillLock && !lockDet) |-> !rfOutEn);

endmodule

// File: tb/pll_lock_monitor_tb_top.sv
module pll_lock_monitor_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 18;

  typedef struct packed {
    logic       prec;
    logic       refFirst;
    logic [7:0] gap;
    logic       expLock;
  } vec_t;

  // {precision, ref leads, error cycles, expected lock after}
  localparam vec_t VECS [N_VEC] = '{
    '{1'b0, 1'b1, 8'd3,  1'b0},
    '{1'b0, 1'b1, 8'd14, 1'b0},
    '{1'b0, 1'b0, 8'd14, 1'b1},  // R2 third small
    '{1'b0, 1'b1, 8'd20, 1'b1},  // R5 mid band
    '{1'b0, 1'b0, 8'd25, 1'b1},  // R5 at exit
    '{1'b0, 1'b1, 8'd26, 1'b0},  // R5 drop
    '{1'b0, 1'b1, 8'd2,  1'b0},
    '{1'b0, 1'b0, 8'd3,  1'b0},
    '{1'b0, 1'b1, 8'd15, 1'b0},  // R4 restart
    '{1'b0, 1'b1, 8'd0,  1'b0},  // R1 coincident
    '{1'b0, 1'b0, 8'd1,  1'b0},
    '{1'b0, 1'b1, 8'd7,  1'b1},
    '{1'b0, 1'b0, 8'd40, 1'b0},
    '{1'b1, 1'b1, 8'd1,  1'b0},
    '{1'b1, 1'b1, 8'd1,  1'b0},
    '{1'b1, 1'b0, 8'd1,  1'b0},
    '{1'b1, 1'b1, 8'd1,  1'b0},
    '{1'b1, 1'b1, 8'd1,  1'b1}   // R3 fifth small
  };

  logic clk = 1'b0;
  logic rstN, powerDown, refEdge, fbEdge, refDivOut, fbDivOut;
  logic precisionSel, muteTillLock, serialData, analogLock;
  logic [2:0] muxSel;
  logic lockDet, rfOutEn, statusOut, statusOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_lock_monitor dut_i (
    .clk(clk), .rstN(rstN), .powerDown(powerDown), .refEdge(refEdge),
    .fbEdge(fbEdge), .refDivOut(refDivOut), .fbDivOut(fbDivOut),
    .precisionSel(precisionSel), .muteTillLock(muteTillLock), .muxSel(muxSel),
    .serialData(serialData), .analogLock(analogLock), .lockDet(lockDet),
    .rfOutEn(rfOutEn), .statusOut(statusOut), .statusOe(statusOe)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic runPhase(logic refFirst, int gap);
    @(negedge clk);
    if (gap == 0) begin refEdge = 1'b1; fbEdge = 1'b1; end
    else if (refFirst) refEdge = 1'b1;
    else fbEdge = 1'b1;
    @(negedge clk);
    refEdge = 1'b0; fbEdge = 1'b0;
    if (gap > 0) begin
      repeat (gap - 1) @(negedge clk);
      if (refFirst) fbEdge = 1'b1; else refEdge = 1'b1;
      @(negedge clk);
      refEdge = 1'b0; fbEdge = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [1:0] expMux(logic [2:0] s, logic lk, logic rd,
                                        logic fd, logic sd, logic al);
    // {oe, out}
    case (s)
      3'b000: return 2'b00;
      3'b001: return {1'b1, lk};
      3'b010: return {1'b1, fd};
      3'b011: return 2'b11;
      3'b100: return {1'b1, rd};
      3'b101: return {!al, 1'b0};
      3'b110: return {1'b1, sd};
      default: return 2'b10;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; powerDown = 1'b0; refEdge = 1'b0; fbEdge = 1'b0;
    refDivOut = 1'b0; fbDivOut = 1'b0; precisionSel = 1'b0;
    muteTillLock = 1'b1; muxSel = 3'b000; serialData = 1'b0; analogLock = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 lockDet after reset", lockDet, 1'b0);
    check("R10 rfOutEn muted after reset", rfOutEn, 1'b0);
    check("R9 hiz oe after reset", statusOe, 1'b0);

    // Vector table: R1..R5
    for (int i = 0; i < N_VEC; i++) begin
      precisionSel = VECS[i].prec;
      runPhase(VECS[i].refFirst, int'(VECS[i].gap));
      check($sformatf("R1-R5 vec%0d lockDet (R2 R3 R4 R5)", i), lockDet, VECS[i].expLock);
    end

    // R7 mute gating while locked
    muteTillLock = 1'b1;
    @(negedge clk);
    check("R7 muted but locked", rfOutEn, 1'b1);

    // R6 power-down clears lock, disables RF
    powerDown = 1'b1;
    @(negedge clk);
    check("R6 lockDet cleared by powerDown", lockDet, 1'b0);
    check("R7 rfOutEn off in powerDown", rfOutEn, 1'b0);
    muteTillLock = 1'b0;
    @(negedge clk);
    check("R7 rfOutEn off in powerDown unmuted", rfOutEn, 1'b0);
    powerDown = 1'b0;
    @(negedge clk);
    check("R7 unmuted unlocked enables", rfOutEn, 1'b1);
    muteTillLock = 1'b1;
    @(negedge clk);
    check("R7 muted unlocked disables", rfOutEn, 1'b0);

    // R6 run count cleared: 4 small, powerDown, then 4 more small must not lock at precision 1
    precisionSel = 1'b1;
    for (int k = 0; k < 4; k++) runPhase(1'b1, 2);
    powerDown = 1'b1;
    @(negedge clk);
    powerDown = 1'b0;
    for (int k = 0; k < 4; k++) runPhase(1'b0, 2);
    check("R6 run restarted after powerDown", lockDet, 1'b0);
    runPhase(1'b1, 2);
    check("R3 locks on fifth after powerDown", lockDet, 1'b1);

    // R6 measurement in progress is abandoned: lead edge, powerDown, lag edge
    @(negedge clk);
    refEdge = 1'b1;
    @(negedge clk);
    refEdge = 1'b0; powerDown = 1'b1;
    @(negedge clk);
    powerDown = 1'b0;
    repeat (40) @(negedge clk);
    check("R6 lock cleared mid-measurement", lockDet, 1'b0);

    // R8 / R9 output selector, lockDet = 0 here
    refDivOut = 1'b1; fbDivOut = 1'b0; serialData = 1'b1;
    for (int al = 0; al < 2; al++) begin
      analogLock = al[0];
      for (int s = 0; s < 8; s++) begin
        logic [1:0] e;
        muxSel = s[2:0];
        #1;
        e = expMux(s[2:0], lockDet, refDivOut, fbDivOut, serialData, analogLock);
        check($sformatf("R8 R9 sel=%0d oe", s), statusOe, e[1]);
        if (e[1]) check($sformatf("R8 R9 sel=%0d out", s), statusOut, e[0]);
      end
    end
    refDivOut = 1'b0; fbDivOut = 1'b1; serialData = 1'b0;
    for (int s = 1; s < 8; s++) begin
      logic [1:0] e;
      muxSel = s[2:0];
      #1;
      e = expMux(s[2:0], lockDet, refDivOut, fbDivOut, serialData, analogLock);
      if (e[1]) check($sformatf("R8 sel=%0d out swapped", s), statusOut, e[0]);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule